// File: doc/BRIEF.md
# Two-Level Segment Range Translation Buffer

This block turns a 64-bit virtual address into a 64-bit address in a global intermediate space, which caches further down the chip use as their full-width tag. Mappings are given per segment: a descriptor names an inclusive address range (low and high address), the intermediate-space address that the range's first byte maps to, and read/write/execute permissions. Inside a segment the mapping is a plain linear offset. The descriptors live in a small fully associative range stage. Each lookup there compares the address against the low and high limits of every entry.

A range compare over every entry is slow, so a page-granular, set-associative stage sits in front of it. When a lookup misses the page stage but hits the range stage, the block builds a page entry for the 4 KB page that holds the address. It does this only when the whole page lies inside the segment. The entry stores the segment's signed displacement, so later accesses to that page skip the range compare. These page entries are derived from descriptors and correspond to nothing held in memory. For that reason, writing any descriptor, or a flush, wipes the whole page stage.

A request is taken when `req_valid` and `req_ready` are both high. The block answers with a one-cycle response that carries exactly one of three flags: hit, miss or fault. On a miss the requester fetches the descriptor from its own tables and writes it through the refill port. The refill lands in the range stage slot chosen by round-robin order.

The controller is a four-state machine:
- IDLE: ready for a request. A taken request moves the machine to PAGE_LOOKUP.
- PAGE_LOOKUP: a page-stage hit moves to REPLY. A page-stage miss moves to RANGE_LOOKUP.
- RANGE_LOOKUP: always moves to REPLY, and may insert a page entry on the way.
- REPLY: presents the response for one cycle, then returns to IDLE.

Top module: `range_xlate_buffer`

## Requirements
- R1: After reset `req_ready` is 1, `resp_valid` is 0 and both stages are empty, so the first lookup reports a miss.
- R2: A range entry matches when low <= address <= high, with both limits inclusive. When several valid entries match, the one in the lowest slot index wins.
- R3: On a hit the output is address - low + target, taken modulo 2^64 over the full 64 bits, and it is the same on the fast and slow paths even when the displacement is not a multiple of 4 KB.
- R4: Permission bits are bit 0 = read, bit 1 = write, bit 2 = execute. `req_kind` 0 is read, 1 is write, 2 is execute, and 3 is reserved and always faults. If the requested kind is not permitted, the response is fault with address 0, and no page entry is created.
- R5: A range hit with permission granted, where the whole 4 KB page holding the address lies inside the segment, creates a page entry. The next access to that page is answered from the page stage with `resp_fast` = 1.
- R6: When the 4 KB page only partly lies inside the segment, no page entry is created, and repeated accesses keep being answered by the range stage with `resp_fast` = 0.
- R7: A lookup that misses both stages responds with miss and address 0. Every response has exactly one of hit, miss and fault set.
- R8: A refill writes the range slot pointed to by a round-robin pointer. The pointer starts at slot 0 after reset and wraps after the last slot, so the oldest descriptor is overwritten.
- R9: Every refill invalidates all page-stage entries.
- R10: `flush` clears both stages in one cycle. A refill presented in the same cycle as a flush is dropped.
- R11: With the accepting edge counted as edge 1, `resp_valid` rises after edge 2 on a page-stage hit and after edge 3 otherwise. It stays high for one cycle, and `req_ready` is low from acceptance until the cycle after the response.
- R12: The page stage selects its set with address bits [12 +: log2(PAGE_SETS)]. PAGE_WAYS pages that share a set can be held at once, and each set replaces its ways in round-robin order starting at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear both stages |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_hit | output | 1 | Translation succeeded |
| resp_miss | output | 1 | No descriptor covers the address |
| resp_fault | output | 1 | Permission refused |
| resp_fast | output | 1 | Answered by the page stage |
| resp_gaddr | output | 64 | Translated intermediate address (0 unless hit) |
| fill_valid | input | 1 | Write a descriptor into the range stage |
| fill_base | input | 64 | Segment low address, inclusive |
| fill_bound | input | 64 | Segment high address, inclusive |
| fill_target | input | 64 | Intermediate address of the segment's low address |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |

## Verification
A request is driven on a falling edge and accepted on the next rising edge. A page-stage answer is visible at the second falling edge after that drive, and a range-stage answer (hit, miss or fault) at the third. The bench's lookup task counts falling edges until `resp_valid` appears and checks that count against the path each requirement predicts. It reads the flags and the address at that same falling edge. Refill and flush are single-cycle pulses, and their effects are checked through the next lookup's flags and its fast-path indication.

// File: rtl/rxb_pkg.sv
package rxb_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PAGE,
        ST_RANGE,
        ST_REPLY
    } xl_state_e;

    localparam int PERM_W = 3;

    // Permission bit layout: [0] read, [1] write, [2] execute
    function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                         input logic [1:0] kind);
        logic ok;
        case (acc_kind_e'(kind))
            KIND_LOAD:  ok = perm[0];
            KIND_STORE: ok = perm[1];
            KIND_FETCH: ok = perm[2];
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rxb_range_stage.sv
module rxb_range_stage
    import rxb_pkg::*;
#(
    parameter int AW         = 64,
    parameter int ENTRIES    = 8,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_base,
    input  logic [AW-1:0]     wr_bound,
    input  logic [AW-1:0]     wr_target,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic [AW-1:0]     look_addr,
    output logic              hit,
    output logic [AW-1:0]     delta,
    output logic [PERM_W-1:0] perm,
    output logic              page_fits
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [AW-1:0]     lo_q    [ENTRIES];
    logic [AW-1:0]     hi_q    [ENTRIES];
    logic [AW-1:0]     disp_q  [ENTRIES];
    logic [PERM_W-1:0] perm_q  [ENTRIES];
    logic              valid_q [ENTRIES];
    logic [IDX_W-1:0]  wr_ptr_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] fits;
    logic [AW-1:0]     page_lo;
    logic [AW-1:0]     page_hi;

    assign page_lo = {look_addr[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    assign page_hi = {look_addr[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b1}}};

    // Round-robin refill pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
        end else if (wr_en && !clear) begin
            wr_ptr_q <= (wr_ptr_q == IDX_W'(ENTRIES-1)) ? '0 : wr_ptr_q + 1'b1;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e] <= 1'b0;
                lo_q[e]    <= '0;
                hi_q[e]    <= '0;
                disp_q[e]  <= '0;
                perm_q[e]  <= '0;
            end else if (clear) begin
                valid_q[e] <= 1'b0;
            end else if (wr_en && wr_ptr_q == IDX_W'(e)) begin
                valid_q[e] <= 1'b1;
                lo_q[e]    <= wr_base;
                hi_q[e]    <= wr_bound;
                disp_q[e]  <= wr_target - wr_base;
                perm_q[e]  <= wr_perm;
            end
        end

        assign match[e] = valid_q[e] && (look_addr >= lo_q[e]) && (look_addr <= hi_q[e]);
        assign fits[e]  = (page_lo >= lo_q[e]) && (page_hi <= hi_q[e]);
    end

    // Lowest matching slot wins
    always_comb begin
        hit       = 1'b0;
        delta     = '0;
        perm      = '0;
        page_fits = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit       = 1'b1;
                delta     = disp_q[i];
                perm      = perm_q[i];
                page_fits = fits[i];
            end
        end
    end

endmodule

// File: rtl/rxb_page_stage.sv
module rxb_page_stage
    import rxb_pkg::*;
#(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int SETS       = 8,
    parameter int WAYS       = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic [AW-PAGE_SHIFT-1:0] look_vpn,
    output logic                     hit,
    output logic [AW-1:0]            delta,
    output logic [PERM_W-1:0]        perm,
    input  logic                     ins_en,
    input  logic [AW-PAGE_SHIFT-1:0] ins_vpn,
    input  logic [AW-1:0]            ins_delta,
    input  logic [PERM_W-1:0]        ins_perm,
    output logic                     any_valid
);

    localparam int VPN_W = AW - PAGE_SHIFT;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int SLOTS = SETS * WAYS;

    logic [TAG_W-1:0]  tag_q   [SLOTS];
    logic [AW-1:0]     disp_q  [SLOTS];
    logic [PERM_W-1:0] perm_q  [SLOTS];
    logic              valid_q [SLOTS];
    logic [WAY_W-1:0]  vic_q   [SETS];

    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic [SET_W-1:0]  ins_set;
    logic [TAG_W-1:0]  ins_tag;

    assign look_set = look_vpn[SET_W-1:0];
    assign look_tag = look_vpn[VPN_W-1:SET_W];
    assign ins_set  = ins_vpn[SET_W-1:0];
    assign ins_tag  = ins_vpn[VPN_W-1:SET_W];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vic_q[s] <= '0;
            end else if (ins_en && !clear && ins_set == SET_W'(s)) begin
                vic_q[s] <= (vic_q[s] == WAY_W'(WAYS-1)) ? '0 : vic_q[s] + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int KS = k / WAYS;
        localparam int KW = k % WAYS;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[k] <= 1'b0;
                tag_q[k]   <= '0;
                disp_q[k]  <= '0;
                perm_q[k]  <= '0;
            end else if (clear) begin
                valid_q[k] <= 1'b0;
            end else if (ins_en && ins_set == SET_W'(KS) && vic_q[KS] == WAY_W'(KW)) begin
                valid_q[k] <= 1'b1;
                tag_q[k]   <= ins_tag;
                disp_q[k]  <= ins_delta;
                perm_q[k]  <= ins_perm;
            end
        end
    end

    always_comb begin
        hit   = 1'b0;
        delta = '0;
        perm  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (valid_q[int'(look_set) * WAYS + w] &&
                tag_q[int'(look_set) * WAYS + w] == look_tag) begin
                hit   = 1'b1;
                delta = disp_q[int'(look_set) * WAYS + w];
                perm  = perm_q[int'(look_set) * WAYS + w];
            end
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int k = 0; k < SLOTS; k++) begin
            any_valid = any_valid | valid_q[k];
        end
    end

endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
    import rxb_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_valid,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              req_ready,
    output logic [AW-1:0]     cap_addr,
    input  logic              page_hit,
    input  logic [AW-1:0]     page_delta,
    input  logic [PERM_W-1:0] page_perm,
    input  logic              range_hit,
    input  logic [AW-1:0]     range_delta,
    input  logic [PERM_W-1:0] range_perm,
    input  logic              range_fits,
    output logic              ins_en,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              resp_fault,
    output logic              resp_fast,
    output logic [AW-1:0]     resp_gaddr
);

    xl_state_e     state_q, state_d;
    logic [1:0]    cap_kind;
    logic          res_hit, res_miss, res_fault, res_fast;
    logic [AW-1:0] res_addr;
    logic          page_ok, range_ok;

    assign page_ok  = perm_allows(page_perm, cap_kind);
    assign range_ok = perm_allows(range_perm, cap_kind);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_PAGE;
            ST_PAGE:  state_d = page_hit ? ST_REPLY : ST_RANGE;
            ST_RANGE: state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
        endcase
    end

    // Captured request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_kind  <= '0;
            res_hit   <= 1'b0;
            res_miss  <= 1'b0;
            res_fault <= 1'b0;
            res_fast  <= 1'b0;
            res_addr  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                cap_addr <= req_vaddr;
                cap_kind <= req_kind;
            end
            if (state_q == ST_PAGE && page_hit) begin
                res_hit   <= page_ok;
                res_fault <= !page_ok;
                res_miss  <= 1'b0;
                res_fast  <= 1'b1;
                res_addr  <= page_ok ? cap_addr + page_delta : '0;
            end
            if (state_q == ST_RANGE) begin
                res_fast  <= 1'b0;
                res_hit   <= range_hit && range_ok;
                res_fault <= range_hit && !range_ok;
                res_miss  <= !range_hit;
                res_addr  <= (range_hit && range_ok) ? cap_addr + range_delta : '0;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_valid = (state_q == ST_REPLY);
        resp_hit   = res_hit;
        resp_miss  = res_miss;
        resp_fault = res_fault;
        resp_fast  = res_fast;
        resp_gaddr = res_addr;
        ins_en     = (state_q == ST_RANGE) && range_hit && range_ok && range_fits
                     && !flush && !fill_valid;
    end

endmodule

// File: rtl/range_xlate_buffer.sv
module range_xlate_buffer
    import rxb_pkg::*;
#(
    parameter int ADDR_W        = 64,
    parameter int RANGE_ENTRIES = 8,
    parameter int PAGE_SETS     = 8,
    parameter int PAGE_WAYS     = 2,
    parameter int PAGE_SHIFT    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              resp_fault,
    output logic              resp_fast,
    output logic [ADDR_W-1:0] resp_gaddr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_base,
    input  logic [ADDR_W-1:0] fill_bound,
    input  logic [ADDR_W-1:0] fill_target,
    input  logic [2:0]        fill_perm
);

    logic [ADDR_W-1:0] cap_addr;
    logic              page_hit, range_hit, range_fits, ins_en;
    logic [ADDR_W-1:0] page_delta, range_delta;
    logic [PERM_W-1:0] page_perm, range_perm;
    logic              page_any_valid;
    logic              page_clear;

    // Page entries derive from descriptors: any refill wipes them
    assign page_clear = flush | fill_valid;

    rxb_ctrl #(.AW(ADDR_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush       (flush),
        .fill_valid  (fill_valid),
        .req_valid   (req_valid),
        .req_vaddr   (req_vaddr),
        .req_kind    (req_kind),
        .req_ready   (req_ready),
        .cap_addr    (cap_addr),
        .page_hit    (page_hit),
        .page_delta  (page_delta),
        .page_perm   (page_perm),
        .range_hit   (range_hit),
        .range_delta (range_delta),
        .range_perm  (range_perm),
        .range_fits  (range_fits),
        .ins_en      (ins_en),
        .resp_valid  (resp_valid),
        .resp_hit    (resp_hit),
        .resp_miss   (resp_miss),
        .resp_fault  (resp_fault),
        .resp_fast   (resp_fast),
        .resp_gaddr  (resp_gaddr)
    );

    rxb_range_stage #(
        .AW(ADDR_W), .ENTRIES(RANGE_ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)
    ) i_range (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .wr_en     (fill_valid),
        .wr_base   (fill_base),
        .wr_bound  (fill_bound),
        .wr_target (fill_target),
        .wr_perm   (fill_perm),
        .look_addr (cap_addr),
        .hit       (range_hit),
        .delta     (range_delta),
        .perm      (range_perm),
        .page_fits (range_fits)
    );

    rxb_page_stage #(
        .AW(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .SETS(PAGE_SETS), .WAYS(PAGE_WAYS)
    ) i_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (page_clear),
        .look_vpn  (cap_addr[ADDR_W-1:PAGE_SHIFT]),
        .hit       (page_hit),
        .delta     (page_delta),
        .perm      (page_perm),
        .ins_en    (ins_en),
        .ins_vpn   (cap_addr[ADDR_W-1:PAGE_SHIFT]),
        .ins_delta (range_delta),
        .ins_perm  (range_perm),
        .any_valid (page_any_valid)
    );

endmodule

// File: rtl/rxb_checker.sv
module rxb_checker #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          fill_valid,
    input logic          req_valid,
    input logic          req_ready,
    input logic          resp_valid,
    input logic          resp_hit,
    input logic          resp_miss,
    input logic          resp_fault,
    input logic          resp_fast,
    input logic [AW-1:0] resp_gaddr,
    input logic          page_any_valid
);

    assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $countones({resp_hit, resp_miss, resp_fault}) == 1);

    assert_zero_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> resp_gaddr == '0);

    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !resp_valid));

    assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && resp_valid));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !page_any_valid);

    assert_fill_invalidates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !page_any_valid);

    assert_miss_not_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_miss) |-> !resp_fast);

endmodule

bind range_xlate_buffer rxb_checker #(.AW(ADDR_W)) u_rxb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .fill_valid     (fill_valid),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .resp_valid     (resp_valid),
    .resp_hit       (resp_hit),
    .resp_miss      (resp_miss),
    .resp_fault     (resp_fault),
    .resp_fast      (resp_fast),
    .resp_gaddr     (resp_gaddr),
    .page_any_valid (page_any_valid)
);

// File: tb/test_range_xlate_buffer.sv
module test_range_xlate_buffer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        resp_valid, resp_hit, resp_miss, resp_fault, resp_fast;
    logic [63:0] resp_gaddr;
    logic        fill_valid = 1'b0;
    logic [63:0] fill_base = '0, fill_bound = '0, fill_target = '0;
    logic [2:0]  fill_perm = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    range_xlate_buffer i_range_xlate_buffer (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_fault(resp_fault), .resp_fast(resp_fast), .resp_gaddr(resp_gaddr),
        .fill_valid(fill_valid), .fill_base(fill_base), .fill_bound(fill_bound),
        .fill_target(fill_target), .fill_perm(fill_perm)
    );

    // last response
    logic        r_hit, r_miss, r_fault, r_fast;
    logic [63:0] r_addr;
    int          r_lat;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [63:0] a, input logic [1:0] k);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = a;
        req_kind  = k;
        r_lat = 0;
        r_hit = 0; r_miss = 0; r_fault = 0; r_fast = 0; r_addr = '0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            r_lat++;
            req_valid = 1'b0;
            if (resp_valid) begin
                r_hit = resp_hit; r_miss = resp_miss; r_fault = resp_fault;
                r_fast = resp_fast; r_addr = resp_gaddr;
                break;
            end
        end
    endtask

    task automatic expect_hit(input logic [63:0] a, input logic [1:0] k, input logic [63:0] exp,
                              input bit fast, input string req);
        lookup(a, k);
        check(r_hit && !r_miss && !r_fault, {req, " hit flag"}, {r_fault, r_miss, r_hit}, 64'd1);
        check(r_addr == exp, {req, " address"}, r_addr, exp);
        check(r_fast == fast, {req, " fast path"}, 64'(r_fast), 64'(fast));
        check(r_lat == (fast ? 2 : 3), {req, " latency R11"}, 64'(r_lat), fast ? 64'd2 : 64'd3);
    endtask

    task automatic expect_miss(input logic [63:0] a, input string req);
        lookup(a, 2'd0);
        check(r_miss && !r_hit && !r_fault, {req, " miss flag"}, {r_fault, r_miss, r_hit}, 64'd2);
        check(r_addr == 64'd0, {req, " miss address"}, r_addr, 64'd0);
        check(r_lat == 3, {req, " miss latency R11"}, 64'(r_lat), 64'd3);
    endtask

    task automatic expect_fault(input logic [63:0] a, input logic [1:0] k, input bit fast, input string req);
        lookup(a, k);
        check(r_fault && !r_hit && !r_miss, {req, " fault flag"}, {r_fault, r_miss, r_hit}, 64'd4);
        check(r_addr == 64'd0, {req, " fault address"}, r_addr, 64'd0);
        check(r_fast == fast, {req, " fault path"}, 64'(r_fast), 64'(fast));
    endtask

    task automatic refill(input logic [63:0] lo, input logic [63:0] hi, input logic [63:0] tgt,
                          input logic [2:0] p, input bit with_flush);
        @(negedge clk);
        fill_valid = 1'b1; fill_base = lo; fill_bound = hi; fill_target = tgt; fill_perm = p;
        flush = with_flush;
        @(negedge clk);
        fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    localparam logic [63:0] S0_LO = 64'h0000_0000_4000_0000;
    localparam logic [63:0] S0_HI = 64'h0000_0000_4000_FFFF;
    localparam logic [63:0] S0_TG = 64'hFFFF_8000_0000_0000;
    localparam logic [63:0] S1_LO = 64'h0000_0000_2000_0800;
    localparam logic [63:0] S1_HI = 64'h0000_0000_2000_27FF;
    localparam logic [63:0] S1_TG = 64'h9000_0000_0000_0000;
    localparam logic [63:0] S2_LO = 64'h0000_0000_4000_0000;
    localparam logic [63:0] S2_HI = 64'h0000_0000_4000_0FFF;
    localparam logic [63:0] S2_TG = 64'h0000_0000_1234_0000;
    localparam logic [63:0] BIG_LO = 64'h0000_0000_8000_0000;
    localparam logic [63:0] BIG_HI = 64'h0000_0000_80FF_FFFF;
    localparam logic [63:0] BIG_TG = 64'h7000_0000_0000_0000;

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(resp_valid == 1'b0, "R1 no response after reset", 64'(resp_valid), 64'd0);
        expect_miss(64'h1000, "R1 R7 empty after reset");
    endtask

    task automatic t_range_map();
        refill(S0_LO, S0_HI, S0_TG, 3'b011, 1'b0);
        expect_hit(S0_LO + 64'h123, 2'd0, S0_LO + 64'h123 - S0_LO + S0_TG, 1'b0, "R3 first range hit");
        expect_hit(S0_HI, 2'd1, S0_HI - S0_LO + S0_TG, 1'b0, "R2 inclusive high limit");
        expect_miss(S0_HI + 64'd1, "R2 above high limit");
        expect_miss(S0_LO - 64'd1, "R2 below low limit");
        expect_hit(S0_LO + 64'h123, 2'd0, S0_LO + 64'h123 - S0_LO + S0_TG, 1'b1, "R5 page entry used");
    endtask

    task automatic t_perm();
        expect_fault(S0_LO + 64'h5000, 2'd2, 1'b0, "R4 execute refused");
        expect_hit(S0_LO + 64'h5010, 2'd0, 64'h5010 + S0_TG, 1'b0, "R4 fault made no page entry");
        expect_hit(S0_LO + 64'h5020, 2'd0, 64'h5020 + S0_TG, 1'b1, "R5 page entry after granted read");
        expect_fault(S0_LO + 64'h5020, 2'd3, 1'b1, "R4 reserved kind faults");
        expect_fault(S0_LO + 64'h123, 2'd2, 1'b1, "R4 execute refused on fast path");
    endtask

    task automatic t_partial();
        refill(S1_LO, S1_HI, S1_TG, 3'b111, 1'b0);
        expect_hit(S0_LO + 64'h123, 2'd0, 64'h123 + S0_TG, 1'b0, "R9 refill wiped page stage");
        expect_hit(64'h2000_0900, 2'd0, S1_TG + 64'h100, 1'b0, "R6 partial page first");
        expect_hit(64'h2000_0900, 2'd0, S1_TG + 64'h100, 1'b0, "R6 partial page repeat");
        expect_hit(64'h2000_1500, 2'd2, S1_TG + 64'hD00, 1'b0, "R3 unaligned displacement slow");
        expect_hit(64'h2000_1504, 2'd1, S1_TG + 64'hD04, 1'b1, "R3 unaligned displacement fast");
    endtask

    task automatic t_priority_and_rr();
        // slot 2: overlaps slot 0, lower slot wins
        refill(S2_LO, S2_HI, S2_TG, 3'b111, 1'b0);
        expect_hit(64'h4000_0010, 2'd0, S0_TG + 64'h10, 1'b0, "R2 lowest slot wins");
        // slots 3..7 then wrap to slot 0
        for (int i = 0; i < 6; i++) begin
            refill(64'h1_0000_0000 * 64'(i + 1), 64'h1_0000_0000 * 64'(i + 1) + 64'hFFF,
                   64'hA000_0000_0000_0000 + 64'h10_0000 * 64'(i), 3'b001, 1'b0);
        end
        expect_miss(S0_LO + 64'h2000, "R8 oldest slot overwritten");
        expect_hit(64'h4000_0010, 2'd0, S2_TG + 64'h10, 1'b0, "R8 R2 overlap now from slot 2");
        expect_hit(64'h2000_0900, 2'd0, S1_TG + 64'h100, 1'b0, "R8 slot 1 retained");
        expect_hit(64'h6_0000_0040, 2'd0, 64'hA000_0000_0050_0040, 1'b0, "R8 wrapped refill present");
    endtask

    task automatic t_sets();
        do_flush();
        expect_miss(64'h2000_0900, "R10 flush cleared range stage");
        refill(BIG_LO, BIG_HI, BIG_TG, 3'b111, 1'b0);
        // same set (8 sets): pages differ by 8 * 4KB
        expect_hit(64'h8000_0004, 2'd0, BIG_TG + 64'h4, 1'b0, "R12 page A fill way0");
        expect_hit(64'h8000_8004, 2'd0, BIG_TG + 64'h8004, 1'b0, "R12 page B fill way1");
        expect_hit(64'h8000_0008, 2'd0, BIG_TG + 64'h8, 1'b1, "R12 page A kept");
        expect_hit(64'h8000_8008, 2'd0, BIG_TG + 64'h8008, 1'b1, "R12 page B kept");
        expect_hit(64'h8001_0004, 2'd0, BIG_TG + 64'h1_0004, 1'b0, "R12 page C fill evicts way0");
        expect_hit(64'h8000_800C, 2'd0, BIG_TG + 64'h800C, 1'b1, "R12 page B survives");
        expect_hit(64'h8000_000C, 2'd0, BIG_TG + 64'hC, 1'b0, "R12 page A evicted");
        do_flush();
        expect_miss(64'h8000_8010, "R10 flush cleared both stages");
    endtask

    task automatic t_flush_with_fill();
        refill(BIG_LO, BIG_HI, BIG_TG, 3'b111, 1'b1);
        expect_miss(64'h8000_0000, "R10 refill dropped under flush");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_range_map();
        t_perm();
        t_partial();
        t_priority_and_rr();
        t_sets();
        t_flush_with_fill();
        done = 1'b1;
        finish_run();
    end

endmodule